// File: doc/BRIEF.md
# Lane-Confined Byte Shifter

This unit moves the bytes of a 256-bit vector left or right by a whole number of bytes. The vector is handled as two 128-bit lanes of 16 bytes each, and each lane is shifted on its own: a byte pushed past the edge of its lane is discarded and is never carried into the neighbouring lane. Byte positions that are vacated are filled with zero bytes.

The shift amount is an 8-bit unsigned byte count. Any amount from 16 up to 255 empties every lane, so the whole result is zero. An operand is offered with a valid/ready pair. Once it is accepted, the shifted vector appears in an output register on the next clock, qualified by an output valid that lasts one cycle for each accepted operand.

Top module: `lane_byte_shifter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `out_valid` = 0, `out_data` = 0 and `in_ready` = 0. After the first edge with `rst_n` high, `in_ready` is 1.
- R2: An operand is accepted when `in_valid` and `in_ready` are both 1 at a rising edge. `out_valid` is 1 in the cycle after each accepted operand and 0 after every edge that accepts nothing.
- R3: With `in_dir` = 0 (toward higher bytes) and count n in 0..15, result byte j of each lane equals input byte j-n of the same lane for j >= n, and is zero for j < n. Byte 0 of a lane is its least significant byte. Lane 0 is bits [127:0] and lane 1 is bits [255:128].
- R4: With `in_dir` = 1 (toward lower bytes) and count n in 0..15, result byte j of each lane equals input byte j+n of the same lane for j+n <= 15, and is zero otherwise.
- R5: No byte crosses between lanes. After a shift toward higher bytes by 1..15, byte 0 of lane 1 is zero. After a shift toward lower bytes by 1..15, byte 15 of lane 0 is zero.
- R6: Any count from 16 to 255 gives an all-zero 256-bit result in either direction.
- R7: A count of 0 returns the input vector unchanged in either direction.
- R8: If no operand is accepted, `out_data` keeps its value, whatever `in_data`, `in_count` and `in_dir` do.
- R9: The whole 8-bit count is decoded as unsigned. Counts whose low four bits are zero or small but whose value is at least 16 (such as 16, 19, 32 and 128) give zero and are not reduced modulo 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can accept an operand |
| in_data | input | 256 | Vector to shift, two 128-bit lanes |
| in_count | input | 8 | Unsigned shift amount in bytes |
| in_dir | input | 1 | 0 = toward higher bytes, 1 = toward lower bytes |
| out_valid | output | 1 | Result register holds a new result this cycle |
| out_data | output | 256 | Registered shifted vector |

## Verification
The bench builds the unit with its default values: 16-byte lanes, two lanes and an 8-bit count. This makes the four-stage shift network and the oversize decode of the upper four count bits both reachable. Two lanes are enough to expose any byte leaking across the lane seam in either direction. The full 8-bit count lets the bench use 16, 19, 32, 128, 200 and 255, which separate a true range check from a modulo-16 wrap.

// File: rtl/lbs_pkg.sv
// Package: shared constants and the direction encoding for the lane byte shifter.
// Assumes: byte width is fixed at eight bits for every lane.
package lbs_pkg;

    localparam int BYTE_W = 8;

    // Direction encoding carried on in_dir.
    typedef enum logic {
        TOWARD_HIGH = 1'b0,
        TOWARD_LOW  = 1'b1
    } lbs_dir_e;

endpackage

// File: rtl/lbs_count_split.sv
// Module: splits the unsigned byte count into the in-lane shift amount and an
// oversize flag. Assumes CNT_W is larger than SEL_W. Any set bit above the
// in-lane field means the count reaches or exceeds one lane width.
module lbs_count_split #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 4
) (
    input  logic [CNT_W-1:0] count,
    output logic [SEL_W-1:0] amt,
    output logic             oversize
);

    localparam int HI_W = CNT_W - SEL_W;

    logic [HI_W-1:0] hi_bits;

    // Split the count into its in-lane part and its overflow part.
    always_comb begin
        amt      = count[SEL_W-1:0];
        hi_bits  = count[CNT_W-1:SEL_W];
        oversize = |hi_bits;
    end

endmodule

// File: rtl/lbs_lane_shift.sv
// Module: byte shifter for one lane, built as a logarithmic chain of stages.
// Stage s moves the lane by 2**s bytes when bit s of amt is set. Bytes that
// leave the lane are lost and zero bytes enter. Assumes LANE_BYTES is a power
// of two and that amt has $clog2(LANE_BYTES) bits.
module lbs_lane_shift
    import lbs_pkg::*;
#(
    parameter int LANE_BYTES = 16,
    parameter int SEL_W      = 4
) (
    input  logic [LANE_BYTES*8-1:0] lane_in,
    input  logic [SEL_W-1:0]        amt,
    input  logic                    dir,
    input  logic                    kill,
    output logic [LANE_BYTES*8-1:0] lane_out
);

    localparam int LANE_W = LANE_BYTES * BYTE_W;

    logic [LANE_W-1:0] stage [0:SEL_W];
    lbs_dir_e          dir_e;

    // Decode the direction into the package enum.
    always_comb begin
        dir_e = lbs_dir_e'(dir);
    end

    // Stage 0 is the raw lane.
    always_comb begin
        stage[0] = lane_in;
    end

    genvar s;
    generate
        for (s = 0; s < SEL_W; s++) begin : g_stage
            localparam int STEP_BITS = (1 << s) * BYTE_W;
            // Move the lane by 2**s bytes when this amount bit is set.
            always_comb begin
                if (!amt[s]) begin
                    stage[s+1] = stage[s];
                end else if (dir_e == TOWARD_HIGH) begin
                    stage[s+1] = stage[s] << STEP_BITS;
                end else begin
                    stage[s+1] = stage[s] >> STEP_BITS;
                end
            end
        end
    endgenerate

    // Force the lane to zero for an oversize count.
    always_comb begin
        lane_out = kill ? '0 : stage[SEL_W];
    end

endmodule

// File: rtl/lbs_result_stage.sv
// Module: input handshake and the output register. It accepts an operand when
// valid meets ready, captures the shifted vector and raises out_valid for one
// cycle. Ready is held low in reset and is high afterwards. Assumes the shifted
// vector is already stable when the operand is offered.
module lbs_result_stage #(
    parameter int VEC_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] shifted,
    output logic             in_ready,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_data
);

    logic             ready_q;
    logic             valid_q;
    logic [VEC_W-1:0] data_q;
    logic             take;

    // Accept an operand when both sides of the handshake agree.
    always_comb begin
        take = in_valid & ready_q;
    end

    // Ready comes up on the first edge out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Register the result and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= take;
            if (take) data_q <= shifted;
        end
    end

    // Drive the outputs from the registers.
    always_comb begin
        in_ready  = ready_q;
        out_valid = valid_q;
        out_data  = data_q;
    end

    // R1: reset clears the outputs and drops ready.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && !in_ready));

    // R2: an accepted operand yields out_valid on the next cycle.
    p_valid_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R2: no acceptance means no valid on the next cycle.
    p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_valid);

    // R8: the result is held while nothing is accepted.
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(out_data));

endmodule

// File: rtl/lane_byte_shifter.sv
// Module: top of the lane-confined byte shifter. It splits the count, runs one
// shift chain per lane and registers the joined result. Assumes LANE_BYTES is a
// power of two and CNT_W is wider than the in-lane amount field.
module lane_byte_shifter
    import lbs_pkg::*;
#(
    parameter int LANE_BYTES = 16,
    parameter int NUM_LANES  = 2,
    parameter int CNT_W      = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic [LANE_BYTES*NUM_LANES*8-1:0]  in_data,
    input  logic [CNT_W-1:0]                   in_count,
    input  logic                               in_dir,
    output logic                               out_valid,
    output logic [LANE_BYTES*NUM_LANES*8-1:0]  out_data
);

    localparam int LANE_W = LANE_BYTES * BYTE_W;
    localparam int VEC_W  = LANE_W * NUM_LANES;
    localparam int SEL_W  = $clog2(LANE_BYTES);
    localparam int TOP_LO = LANE_W - BYTE_W;

    logic [SEL_W-1:0] amt;
    logic             oversize;
    logic [VEC_W-1:0] shifted;

    lbs_count_split #(
        .CNT_W (CNT_W),
        .SEL_W (SEL_W)
    ) u_split (
        .count    (in_count),
        .amt      (amt),
        .oversize (oversize)
    );

    genvar l;
    generate
        for (l = 0; l < NUM_LANES; l++) begin : g_lane
            lbs_lane_shift #(
                .LANE_BYTES (LANE_BYTES),
                .SEL_W      (SEL_W)
            ) u_lane (
                .lane_in  (in_data[l*LANE_W +: LANE_W]),
                .amt      (amt),
                .dir      (in_dir),
                .kill     (oversize),
                .lane_out (shifted[l*LANE_W +: LANE_W])
            );

            // R3: after a shift toward higher bytes, the lane's byte 0 is zero.
            p_left_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_ready && in_dir == TOWARD_HIGH && in_count != '0)
                |=> out_data[l*LANE_W +: BYTE_W] == '0);

            // R4: after a shift toward lower bytes, the lane's top byte is zero.
            p_right_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_ready && in_dir == TOWARD_LOW && in_count != '0)
                |=> out_data[l*LANE_W + TOP_LO +: BYTE_W] == '0);

            // R5: the byte at the lane seam never takes its neighbour's byte.
            p_seam_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_ready && in_count == CNT_W'(1) &&
                 in_data[l*LANE_W +: LANE_W] == '0)
                |=> out_data[l*LANE_W +: LANE_W] == '0);
        end
    endgenerate

    lbs_result_stage #(
        .VEC_W (VEC_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .shifted   (shifted),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R6: an oversize count empties the whole vector.
    p_oversize_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_count >= CNT_W'(LANE_BYTES))
        |=> out_data == '0);

    // R7: a zero count passes the operand through.
    p_zero_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_count == '0)
        |=> out_data == $past(in_data));

    // R9: counts with a clear in-lane field but a high bit set are not wrapped.
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_count[SEL_W-1:0] == '0 && in_count != '0)
        |=> out_data == '0);

endmodule

// File: tb/sim_lane_byte_shifter.sv
module sim_lane_byte_shifter;

    localparam int NB = 16;
    localparam int NL = 2;
    localparam int VW = NB * NL * 8;

    logic          clk;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [VW-1:0] in_data;
    logic [7:0]    in_count;
    logic          in_dir;
    logic          out_valid;
    logic [VW-1:0] out_data;

    int total;
    int bad;

    lane_byte_shifter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_count  (in_count),
        .in_dir    (in_dir),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Reference: byte-by-byte result from the requirements.
    function automatic logic [VW-1:0] model(input logic [VW-1:0] d,
                                            input int n, input logic dir);
        logic [VW-1:0] r;
        r = '0;
        if (n < NB) begin
            for (int ln = 0; ln < NL; ln++) begin
                for (int j = 0; j < NB; j++) begin
                    int src;
                    src = dir ? j + n : j - n;
                    if (src >= 0 && src < NB)
                        r[(ln*NB + j)*8 +: 8] = d[(ln*NB + src)*8 +: 8];
                end
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] ramp(input int base);
        logic [VW-1:0] r;
        for (int b = 0; b < NB*NL; b++) r[b*8 +: 8] = 8'(base + b);
        return r;
    endfunction

    task automatic chk_vec(input string req, input logic [VW-1:0] act,
                           input logic [VW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Offer one operand and check the result the next cycle.
    task automatic run_op(input string req, input logic [VW-1:0] d,
                          input int n, input logic dir);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_count = 8'(n);
        in_dir   = dir;
        @(negedge clk);
        in_valid = 1'b0;
        chk_bit(req, out_valid, 1'b1);
        chk_vec(req, out_data, model(d, n, dir));
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_count = '0; in_dir = 1'b0;
        repeat (3) @(negedge clk);
        chk_bit("R1 valid", out_valid, 1'b0);
        chk_vec("R1 data", out_data, '0);
        chk_bit("R1 ready low", in_ready, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bit("R1 ready high", in_ready, 1'b1);
    endtask

    task automatic t_left;
        run_op("R3 left 3", ramp(1), 3, 1'b0);
        run_op("R3 left 15", ramp(8'h40), 15, 1'b0);
        run_op("R3 left 1", {8{32'hDEADBEEF}}, 1, 1'b0);
    endtask

    task automatic t_right;
        run_op("R4 right 5", ramp(1), 5, 1'b1);
        run_op("R4 right 15", ramp(8'h80), 15, 1'b1);
        run_op("R4 right 8", {8{32'h01234567}}, 8, 1'b1);
    endtask

    task automatic t_seam;
        logic [VW-1:0] d;
        d = '0; d[15*8 +: 8] = 8'hAA;
        run_op("R5 left seam", d, 1, 1'b0);
        chk_vec("R5 lane1 byte0", {248'd0, out_data[128 +: 8]}, '0);
        d = '0; d[16*8 +: 8] = 8'h55;
        run_op("R5 right seam", d, 1, 1'b1);
        chk_vec("R5 lane0 byte15", {248'd0, out_data[120 +: 8]}, '0);
    endtask

    task automatic t_zero;
        run_op("R7 zero left", ramp(3), 0, 1'b0);
        chk_vec("R7 pass left", out_data, ramp(3));
        run_op("R7 zero right", ramp(9), 0, 1'b1);
        chk_vec("R7 pass right", out_data, ramp(9));
    endtask

    task automatic t_large;
        run_op("R6 count 16 left", ramp(1), 16, 1'b0);
        run_op("R6 count 200 right", ramp(1), 200, 1'b1);
        run_op("R6 count 255 left", '1, 255, 1'b0);
        chk_vec("R6 all zero", out_data, '0);
    endtask

    task automatic t_wrap;
        run_op("R9 count 32", ramp(5), 32, 1'b0);
        run_op("R9 count 128", ramp(5), 128, 1'b1);
        run_op("R9 count 19", ramp(5), 19, 1'b0);
        chk_vec("R9 not wrapped", out_data, '0);
    endtask

    task automatic t_valid;
        run_op("R2 first", ramp(2), 2, 1'b0);
        @(negedge clk);
        chk_bit("R2 drops", out_valid, 1'b0);
        // Back-to-back operands keep valid high on consecutive cycles.
        @(negedge clk);
        in_valid = 1'b1; in_data = ramp(7); in_count = 8'd4; in_dir = 1'b1;
        @(negedge clk);
        chk_bit("R2 b2b first", out_valid, 1'b1);
        chk_vec("R2 b2b first data", out_data, model(ramp(7), 4, 1'b1));
        in_data = ramp(11); in_count = 8'd6; in_dir = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk_bit("R2 b2b second", out_valid, 1'b1);
        chk_vec("R2 b2b second data", out_data, model(ramp(11), 6, 1'b0));
    endtask

    task automatic t_hold;
        logic [VW-1:0] keep;
        run_op("R8 setup", ramp(20), 2, 1'b1);
        keep = model(ramp(20), 2, 1'b1);
        @(negedge clk);
        in_valid = 1'b0; in_data = '1; in_count = 8'd0; in_dir = 1'b0;
        @(negedge clk);
        in_count = 8'd200;
        @(negedge clk);
        chk_bit("R8 no valid", out_valid, 1'b0);
        chk_vec("R8 held", out_data, keep);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        total = 0;
        bad   = 0;
        t_reset();
        t_left();
        t_right();
        t_seam();
        t_zero();
        t_large();
        t_wrap();
        t_valid();
        t_hold();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule